// File: doc/BRIEF.md
# Shared-Bus Flash Access Sequencer

This block lets a controller with only a few pins read and write a parallel flash that needs sixteen address bits and eight data bits. One 8-bit bidirectional bus carries everything. Two external 8-bit edge-triggered registers sit on that bus: one captures the low address byte and the other captures the high byte, each on a rising edge of its own load clock. The flash chip-enable, output-enable and write-enable strobes are driven directly, apart from the bus. In total the flash side uses thirteen pins: eight bus lines, two load clocks and three strobes. The top address bit of the flash is tied low.

A request supplies an address, write data and a direction. The sequencer first puts the low address byte on the bus and pulses the low load clock. If the high byte differs from the last one loaded, or no high byte has been loaded since reset, it then does the same for the high byte. With both load clocks low, the bus reaches the flash data pins. A write drives the data while the write strobe is low. A read releases the bus, lowers the output strobe and samples the returned byte. A one-cycle done pulse ends each access. Read data is returned with that pulse.

Top module: `lmx_flash_seq`

## Requirements
- R1: After reset, all three strobes (`flash_ce_n`, `flash_oe_n`, `flash_we_n`) are high, both load clocks are low, `bus_oe` is 0, `rsp_done` is 0 and `req_ready` is 1.
- R2: Every access loads `req_addr[7:0]` into the low register with a single-cycle pulse of `lat_lo_clk` while `lat_hi_clk` stays low. The bus is driven with that byte for at least one cycle before the rising edge and at least one cycle after the pulse.
- R3: `req_addr[15:8]` is loaded into the high register by a single-cycle pulse of `lat_hi_clk`, with `lat_lo_clk` low and the same setup and hold timing as R2. The load is skipped when that byte equals the high byte last loaded since reset. The first access after reset always loads it.
- R4: The two load clocks are never high together. The write and output strobes go low only while both load clocks are low.
- R5: On a write (`req_write`=1), `flash_we_n` is low for STROBE_CYC cycles. The bus is driven with `req_wdata` for the whole low period and for one cycle after `flash_we_n` returns high.
- R6: On a read (`req_write`=0), `bus_oe` falls at least one cycle before `flash_oe_n` goes low. The bus stays released while `flash_oe_n` is low, which lasts STROBE_CYC cycles. `rsp_rdata` is the value of `bus_in` on the last cycle of that low period.
- R7: `flash_oe_n` and `flash_we_n` are never low together. `flash_ce_n` is low for the whole of an access and high when idle.
- R8: `rsp_done` is a one-cycle pulse in the first idle cycle after the strobe has returned high. `req_ready` is 1 only when idle. A `req_valid` raised during an access has no effect.
- R9: Access length in cycles, counted from the accepting clock edge to the edge that raises `rsp_done`, is (SETUP_CYC+1+HOLD_CYC) per address byte loaded. A write then adds STROBE_CYC+1; a read adds TURN_CYC+STROBE_CYC+1.
- R10: `flash_a16` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Flash address, low 16 bits |
| req_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | 8 | Read result, valid with `rsp_done` |
| bus_out | output | 8 | Shared bus value when driven |
| bus_oe | output | 1 | Shared bus drive enable |
| bus_in | input | 8 | Shared bus value seen by the controller |
| lat_lo_clk | output | 1 | Load clock of the low address register |
| lat_hi_clk | output | 1 | Load clock of the high address register |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_a16 | output | 1 | Flash top address bit, held 0 |

## Verification
The assertions assume that `bus_in` carries the flash output only while the output strobe is low. They also assume that a request is accepted only in a cycle with `req_ready` high. The timing properties further assume SETUP_CYC, HOLD_CYC and TURN_CYC are each at least 1. The bench stays within these assumptions: its flash model drives the bus only while both the chip-enable and output strobes are low, it raises `req_valid` outside idle only on purpose to show that the request is ignored, and it keeps the default timing parameters.

// File: rtl/lmx_pkg.sv
package lmx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LO_SET,
        ST_LO_CLK,
        ST_LO_HOLD,
        ST_HI_SET,
        ST_HI_CLK,
        ST_HI_HOLD,
        ST_WR_STB,
        ST_WR_REC,
        ST_RD_TURN,
        ST_RD_STB,
        ST_RD_REC
    } lmx_state_e;

endpackage

// File: rtl/lmx_hi_cache.sv
module lmx_hi_cache #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] cur_hi,
    output logic              match
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] byte_v;
    } cache_t;

    cache_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        if (load) begin
            c_d.valid  = 1'b1;
            c_d.byte_v = cur_hi;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign match = c_q.valid && (c_q.byte_v == cur_hi);

    // R3: once a high byte has been loaded, the same byte matches on the next cycle
    a_r3_cache_hit: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> match);

endmodule

// File: rtl/lmx_seq_ctrl.sv
module lmx_seq_ctrl
    import lmx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 2,
    parameter int HOLD_CYC   = 1,
    parameter int STROBE_CYC = 3,
    parameter int TURN_CYC   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [2*DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W-1:0]   bus_in,
    input  logic                hi_match,
    output logic                req_ready,
    output logic                rsp_done,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [DATA_W-1:0]   bus_out,
    output logic                bus_oe,
    output logic                lat_lo_clk,
    output logic                lat_hi_clk,
    output logic                ce_n,
    output logic                oe_n,
    output logic                we_n,
    output logic                hi_load,
    output logic [DATA_W-1:0]   cur_hi
);
    localparam int ADDR_W  = 2 * DATA_W;
    localparam int MAX_CYC = (SETUP_CYC > STROBE_CYC) ?
                             ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                             ((STROBE_CYC > TURN_CYC) ? STROBE_CYC : TURN_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

    typedef struct packed {
        lmx_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              wr;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_t;

    seq_t r_q, r_d;
    lmx_state_e nxt;

    // cycles spent in a state, minus one
    function automatic logic [CNT_W-1:0] stay_len(input lmx_state_e s);
        case (s)
            ST_LO_SET, ST_HI_SET:   stay_len = CNT_W'(SETUP_CYC - 1);
            ST_LO_HOLD, ST_HI_HOLD: stay_len = CNT_W'(HOLD_CYC - 1);
            ST_WR_STB, ST_RD_STB:   stay_len = CNT_W'(STROBE_CYC - 1);
            ST_RD_TURN:             stay_len = CNT_W'(TURN_CYC - 1);
            default:                stay_len = '0;
        endcase
    endfunction

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        nxt      = r_q.state;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.wr    = req_write;
                    nxt       = ST_LO_SET;
                end
            end
            ST_LO_SET:  if (r_q.cnt == '0) nxt = ST_LO_CLK;
            ST_LO_CLK:  nxt = ST_LO_HOLD;
            ST_LO_HOLD: begin
                if (r_q.cnt == '0) begin
                    if (!hi_match)    nxt = ST_HI_SET;
                    else if (r_q.wr)  nxt = ST_WR_STB;
                    else              nxt = ST_RD_TURN;
                end
            end
            ST_HI_SET:  if (r_q.cnt == '0) nxt = ST_HI_CLK;
            ST_HI_CLK:  nxt = ST_HI_HOLD;
            ST_HI_HOLD: begin
                if (r_q.cnt == '0) nxt = r_q.wr ? ST_WR_STB : ST_RD_TURN;
            end
            ST_WR_STB:  if (r_q.cnt == '0) nxt = ST_WR_REC;
            ST_WR_REC: begin
                nxt      = ST_IDLE;
                r_d.done = 1'b1;
            end
            ST_RD_TURN: if (r_q.cnt == '0) nxt = ST_RD_STB;
            ST_RD_STB: begin
                if (r_q.cnt == '0) begin
                    r_d.rdata = bus_in;
                    nxt       = ST_RD_REC;
                end
            end
            ST_RD_REC: begin
                nxt      = ST_IDLE;
                r_d.done = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
        r_d.state = nxt;
        if (nxt != r_q.state)       r_d.cnt = stay_len(nxt);
        else if (r_q.cnt != '0)     r_d.cnt = r_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // output decode from registered state
    always_comb begin
        bus_oe     = 1'b0;
        bus_out    = '0;
        lat_lo_clk = 1'b0;
        lat_hi_clk = 1'b0;
        case (r_q.state)
            ST_LO_SET, ST_LO_CLK, ST_LO_HOLD: begin
                bus_oe  = 1'b1;
                bus_out = r_q.addr[DATA_W-1:0];
            end
            ST_HI_SET, ST_HI_CLK, ST_HI_HOLD: begin
                bus_oe  = 1'b1;
                bus_out = r_q.addr[ADDR_W-1:DATA_W];
            end
            ST_WR_STB, ST_WR_REC: begin
                bus_oe  = 1'b1;
                bus_out = r_q.wdata;
            end
            default: ;
        endcase
        lat_lo_clk = (r_q.state == ST_LO_CLK);
        lat_hi_clk = (r_q.state == ST_HI_CLK);
    end

    assign ce_n      = (r_q.state == ST_IDLE);
    assign we_n      = (r_q.state != ST_WR_STB);
    assign oe_n      = (r_q.state != ST_RD_STB);
    assign req_ready = (r_q.state == ST_IDLE);
    assign rsp_done  = r_q.done;
    assign rsp_rdata = r_q.rdata;
    assign hi_load   = lat_hi_clk;
    assign cur_hi    = r_q.addr[ADDR_W-1:DATA_W];

    // R4: load clocks are mutually exclusive
    a_r4_clk_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lat_lo_clk && lat_hi_clk));
    // R4: strobes only in the data phase
    a_r4_strobe_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> (!lat_lo_clk && !lat_hi_clk));
    // R7: never read and write strobe together
    a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));
    // R7: chip enable covers every strobe
    a_r7_ce_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n || !we_n) |-> !ce_n);
    // R2: low-byte setup
    a_r2_lo_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_lo_clk) |-> ($stable(bus_out) && $past(bus_oe)));
    // R2: low-byte hold
    a_r2_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lat_lo_clk) |-> ($stable(bus_out) && bus_oe));
    // R3: high-byte setup
    a_r3_hi_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_hi_clk) |-> ($stable(bus_out) && $past(bus_oe)));
    // R5: write data held one cycle past the write strobe
    a_r5_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (bus_oe && $stable(bus_out)));
    // R6: bus released before output strobe falls
    a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> !$past(bus_oe));
    // R6: no drive while flash drives
    a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !bus_oe);
    // R8: done is a single-cycle pulse and lands in idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (req_ready && ce_n));

endmodule

// File: rtl/lmx_flash_seq.sv
module lmx_flash_seq #(
    parameter int DATA_W     = 8,
    parameter int SETUP_CYC  = 2,
    parameter int HOLD_CYC   = 1,
    parameter int STROBE_CYC = 3,
    parameter int TURN_CYC   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [2*DATA_W-1:0] req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_done,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic [DATA_W-1:0]   bus_out,
    output logic                bus_oe,
    input  logic [DATA_W-1:0]   bus_in,
    output logic                lat_lo_clk,
    output logic                lat_hi_clk,
    output logic                flash_ce_n,
    output logic                flash_oe_n,
    output logic                flash_we_n,
    output logic                flash_a16
);
    logic              hi_match;
    logic              hi_load;
    logic [DATA_W-1:0] cur_hi;

    lmx_seq_ctrl #(
        .DATA_W    (DATA_W),
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .STROBE_CYC(STROBE_CYC),
        .TURN_CYC  (TURN_CYC)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (bus_in),
        .hi_match  (hi_match),
        .req_ready (req_ready),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .lat_lo_clk(lat_lo_clk),
        .lat_hi_clk(lat_hi_clk),
        .ce_n      (flash_ce_n),
        .oe_n      (flash_oe_n),
        .we_n      (flash_we_n),
        .hi_load   (hi_load),
        .cur_hi    (cur_hi)
    );

    lmx_hi_cache #(.DATA_W(DATA_W)) u_hi_cache (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hi_load),
        .cur_hi(cur_hi),
        .match (hi_match)
    );

    // R10: top flash address bit tied low
    assign flash_a16 = 1'b0;

endmodule

// File: tb/tb_lmx_flash_seq.sv
module tb_lmx_flash_seq;
    localparam int CLK_PERIOD = 10;
    localparam int SETUP_CYC  = 2;
    localparam int HOLD_CYC   = 1;
    localparam int STROBE_CYC = 3;
    localparam int TURN_CYC   = 1;
    localparam int BYTE_CYC   = SETUP_CYC + 1 + HOLD_CYC;
    localparam int WR_CYC     = STROBE_CYC + 1;
    localparam int RD_CYC     = TURN_CYC + STROBE_CYC + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done, bus_oe;
    logic [7:0]  rsp_rdata, bus_out, bus_in;
    logic        lat_lo_clk, lat_hi_clk, flash_ce_n, flash_oe_n, flash_we_n, flash_a16;

    int errs = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lmx_flash_seq #(
        .DATA_W(8), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
        .STROBE_CYC(STROBE_CYC), .TURN_CYC(TURN_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_out(bus_out),
        .bus_oe(bus_oe), .bus_in(bus_in), .lat_lo_clk(lat_lo_clk),
        .lat_hi_clk(lat_hi_clk), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
        .flash_we_n(flash_we_n), .flash_a16(flash_a16)
    );

    // external address registers and flash model
    logic [7:0]  ext_lo = '0, ext_hi = '0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    int lo_pulses = 0, hi_pulses = 0, viol = 0, wr_count = 0;

    function automatic logic [7:0] flash_val(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
    endfunction

    always @(posedge lat_lo_clk) if (rst_n) begin
        ext_lo <= bus_out; lo_pulses++;
        if (!bus_oe) viol++;
    end
    always @(posedge lat_hi_clk) if (rst_n) begin
        ext_hi <= bus_out; hi_pulses++;
        if (!bus_oe) viol++;
    end
    always @(negedge flash_we_n) if (rst_n) wr_addr <= {ext_hi, ext_lo};
    always @(posedge flash_we_n) if (rst_n) begin
        wr_data <= bus_out; wr_count++;
        if (!bus_oe) viol++;
    end

    assign bus_in = (!flash_ce_n && !flash_oe_n) ? flash_val({ext_hi, ext_lo}) : 8'h00;

    // protocol monitor (R4, R6, R7)
    always @(negedge clk) if (rst_n) begin
        if (lat_lo_clk && lat_hi_clk) viol++;
        if (!flash_oe_n && !flash_we_n) viol++;
        if (!flash_oe_n && bus_oe) viol++;
        if (flash_ce_n && (!flash_oe_n || !flash_we_n)) viol++;
        if ((!flash_oe_n || !flash_we_n) && (lat_lo_clk || lat_hi_clk)) viol++;
        if (flash_a16 !== 1'b0) viol++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one access; returns the cycle count and read data
    task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d,
                          input bit poke_busy, output int cyc, output logic [7:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_write = ~wr;
        cyc = 0;
        while (!rsp_done && cyc < 200) begin
            if (poke_busy && cyc == 2) req_valid = 1'b1;
            if (poke_busy && cyc == 4) req_valid = 1'b0;
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        rd = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check(flash_ce_n && flash_oe_n && flash_we_n, "R1 strobes high",
              {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
        check(!lat_lo_clk && !lat_hi_clk && !bus_oe, "R1 clocks/bus idle",
              {lat_lo_clk, lat_hi_clk, bus_oe}, 0);
        check(req_ready && !rsp_done, "R1 ready, no done", {req_ready, rsp_done}, 2'b10);
        check(flash_a16 == 1'b0, "R10 a16 low", flash_a16, 0);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [7:0] d, input bit exp_hi);
        int cyc, lo0, hi0, wc0; logic [7:0] rd;
        lo0 = lo_pulses; hi0 = hi_pulses; wc0 = wr_count;
        access(1'b1, a, d, 1'b0, cyc, rd);
        check(lo_pulses - lo0 == 1, "R2 one low pulse", lo_pulses - lo0, 1);
        check(hi_pulses - hi0 == int'(exp_hi), "R3 high load count", hi_pulses - hi0, int'(exp_hi));
        check(wr_count - wc0 == 1 && wr_addr == a, "R2 R3 write address", wr_addr, a);
        check(wr_data == d, "R5 write data", wr_data, d);
        check(cyc == BYTE_CYC * (exp_hi ? 2 : 1) + WR_CYC, "R9 write length",
              cyc, BYTE_CYC * (exp_hi ? 2 : 1) + WR_CYC);
        @(negedge clk);
        check(!rsp_done && req_ready && flash_ce_n, "R8 done pulse single, idle",
              {rsp_done, req_ready, flash_ce_n}, 3'b011);
    endtask

    task automatic t_read(input logic [15:0] a, input bit exp_hi);
        int cyc, hi0; logic [7:0] rd;
        hi0 = hi_pulses;
        access(1'b0, a, 8'h00, 1'b0, cyc, rd);
        check(hi_pulses - hi0 == int'(exp_hi), "R3 high load count (read)", hi_pulses - hi0, int'(exp_hi));
        check(rd == flash_val(a), "R6 read data", rd, flash_val(a));
        check(cyc == BYTE_CYC * (exp_hi ? 2 : 1) + RD_CYC, "R9 read length",
              cyc, BYTE_CYC * (exp_hi ? 2 : 1) + RD_CYC);
    endtask

    task automatic t_busy_ignored;
        int cyc, lo0; logic [7:0] rd;
        access(1'b1, 16'h1234, 8'hC3, 1'b1, cyc, rd);
        check(wr_addr == 16'h1234 && wr_data == 8'hC3, "R8 busy request ignored (write)",
              wr_data, 8'hC3);
        lo0 = lo_pulses;
        repeat (6) @(negedge clk);
        check(lo_pulses == lo0 && req_ready && flash_ce_n, "R8 no extra access after busy poke",
              lo_pulses - lo0, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write(16'h12A5, 8'h3C, 1'b1);   // first access always loads high byte
        t_write(16'h1207, 8'h81, 1'b0);   // same high byte: skipped
        t_read (16'h12FF, 1'b0);
        t_read (16'h3400, 1'b1);          // new high byte
        t_read (16'h3401, 1'b0);
        t_write(16'h0000, 8'hFF, 1'b1);
        t_read (16'hFFFF, 1'b1);
        t_write(16'hFFFE, 8'h00, 1'b0);
        t_busy_ignored();
        t_read (16'h1234, 1'b0);
        check(viol == 0, "R4 R6 R7 protocol monitor", viol, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule